// File: doc/BRIEF.md
# Two-Way Event Trigger Bridge

This block carries single events across a clock boundary in both directions for a bank of 32 independent trigger bits. On the host side of the bank, a write strobe with a bit pattern requests a pulse on each selected bit. The block moves each request into the user clock domain and emits a pulse exactly one user clock wide on the matching output bit. The user logic never has to handle the crossing.

The return path watches a vector of user signals in the user clock. A bit has an event when the signal is sampled low at one user clock edge and high at the next. Events gather in the user domain and cross to the host domain as a bundle, under a request/acknowledge handshake. There they set sticky flags. A host poll strobe returns the flag vector and clears the returned bits in the same cycle. An event that lands in that cycle survives for the next poll.

The request side of each bit is a two-state machine in the host domain. LANE_IDLE goes to LANE_SENT when a request (new or pending) flips the bit's request toggle. LANE_SENT goes back to LANE_IDLE once the acknowledge toggle returned from the user domain matches the request toggle. The event side has a two-state machine in the user domain. XF_IDLE goes to XF_WAIT when any event is pending: the pending set is latched into a transfer register and the transfer toggle flips. XF_WAIT goes back to XF_IDLE when the host's acknowledge toggle matches.

Top module: `evt_trigger_bridge`

## Requirements
- R1: After reset, `usr_trig` is all zero, `poll_flags` is all zero, and a first poll returns zero.
- R2: A host write (`trig_wr_en` high for one host cycle) with pattern `trig_wr_bits` produces exactly one pulse on `usr_trig[i]` for each bit i that is 1 in the pattern. Bits that are 0 in the pattern get no pulse.
- R3: Every pulse on a `usr_trig` bit is high for exactly one `usr_clk` cycle.
- R4: Writes that select a bit while that bit's previous request is unacknowledged (state LANE_SENT) are held. They merge into one further pulse, so three writes to the same bit on consecutive host cycles give exactly two pulses.
- R5: An event on bit i is `usr_evt[i]` sampled 0 at one `usr_clk` rising edge and 1 at the next. A level held high gives one event only.
- R6: A high excursion of `usr_evt` that begins and ends between two `usr_clk` rising edges sets no flag.
- R7: Once set, a flag stays set in the host domain for any number of cycles until a poll clears it.
- R8: A poll (`poll_req` high for one host cycle) loads `poll_flags` with the flag vector at the next `host_clk` edge and clears those flags. `poll_flags` holds its value until the next poll, and a poll with no events returns zero.
- R9: Several rising edges on one bit between two polls show up as a single set bit in one poll, and the next poll returns that bit clear.
- R10: No event is lost or reported twice around a poll. An edge whose transfer reaches the host in the poll cycle is reported by the following poll, and the bundle in flight is held stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host-side clock |
| host_rst_n | input | 1 | Host-side asynchronous reset, active low |
| trig_wr_en | input | 1 | Host write strobe for the trigger-in pattern |
| trig_wr_bits | input | 32 | Bits to pulse in the user domain |
| poll_req | input | 1 | Host poll strobe: read and clear the event flags |
| poll_flags | output | 32 | Flag vector returned by the last poll |
| usr_clk | input | 1 | User clock for trigger pulses and event sampling |
| usr_rst_n | input | 1 | User-side asynchronous reset, active low |
| usr_evt | input | 32 | User signals watched for rising edges |
| usr_trig | output | 32 | One-cycle trigger pulses in the user clock |

## Verification
The bench sends three writes to one bit on consecutive host cycles. A lane that toggled again before its acknowledge returned would cancel its own request and give zero or one pulse instead of two. It places a high excursion wholly between two user edges, and a design that reacted to the level asynchronously would raise a flag. It holds a signal high across polls and strikes one bit several times between polls, which catches level sensitivity or per-edge counting. It also sweeps the poll across twelve phases of an arriving event. A clear that wiped the event landing in the poll cycle would drop the event, and a merge into both the read and the kept flags would report it twice.

// File: rtl/evt_bridge_pkg.sv
package evt_bridge_pkg;

    localparam int unsigned BANK_W = 32;

    typedef enum logic {
        LANE_IDLE = 1'b0,
        LANE_SENT = 1'b1
    } lane_state_e;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_WAIT = 1'b1
    } xfer_state_e;

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/evt_tin_lane.sv
module evt_tin_lane
    import evt_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ack_tog,
    output logic req_tog,
    output logic busy
);

    lane_state_e state_q, state_d;
    logic        tog_d;
    logic        pend_q, pend_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_IDLE;
            req_tog <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            req_tog <= tog_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tog_d   = req_tog;
        pend_d  = pend_q;
        unique case (state_q)
            LANE_IDLE: begin
                if (req || pend_q) begin
                    tog_d   = ~req_tog;
                    pend_d  = 1'b0;
                    state_d = LANE_SENT;
                end
            end
            LANE_SENT: begin
                if (req) begin
                    pend_d = 1'b1;
                end
                if (ack_tog == req_tog) begin
                    state_d = LANE_IDLE;
                end
            end
            default: state_d = LANE_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == LANE_SENT);
    end

endmodule

// File: rtl/evt_tin_bank.sv
module evt_tin_bank #(
    parameter int unsigned W           = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         host_clk,
    input  logic         host_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_bits,
    input  logic         usr_clk,
    input  logic         usr_rst_n,
    output logic [W-1:0] usr_trig,
    output logic [W-1:0] busy,
    output logic [W-1:0] req_tog
);

    logic [W-1:0] ack_tog_h;
    logic [W-1:0] req_tog_u;
    logic [W-1:0] seen_u;

    for (genvar i = 0; i < W; i++) begin : g_lane
        evt_tin_lane i_lane (
            .clk     (host_clk),
            .rst_n   (host_rst_n),
            .req     (wr_en & wr_bits[i]),
            .ack_tog (ack_tog_h[i]),
            .req_tog (req_tog[i]),
            .busy    (busy[i])
        );
    end

    evt_sync #(.W(W), .STAGES(SYNC_STAGES)) i_req_sync (
        .clk   (usr_clk),
        .rst_n (usr_rst_n),
        .d     (req_tog),
        .q     (req_tog_u)
    );

    always_ff @(posedge usr_clk or negedge usr_rst_n) begin
        if (!usr_rst_n) begin
            seen_u   <= '0;
            usr_trig <= '0;
        end else begin
            seen_u   <= req_tog_u;
            usr_trig <= req_tog_u ^ seen_u;
        end
    end

    evt_sync #(.W(W), .STAGES(SYNC_STAGES)) i_ack_sync (
        .clk   (host_clk),
        .rst_n (host_rst_n),
        .d     (seen_u),
        .q     (ack_tog_h)
    );

endmodule

// File: rtl/evt_tout_cap.sv
module evt_tout_cap
    import evt_bridge_pkg::*;
#(
    parameter int unsigned W           = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         usr_clk,
    input  logic         usr_rst_n,
    input  logic [W-1:0] usr_evt,
    input  logic         host_clk,
    input  logic         host_rst_n,
    input  logic         poll_req,
    output logic [W-1:0] poll_flags,
    output logic [W-1:0] flags,
    output xfer_state_e  xf_state,
    output logic [W-1:0] xfer
);

    // user domain
    logic [W-1:0] samp_q, prev_q, rise;
    logic [W-1:0] acc_q, acc_d;
    logic [W-1:0] xfer_d;
    xfer_state_e  state_d;
    logic         tog_u, tog_d;
    logic         ack_u;

    // host domain
    logic         tog_h, seen_h, arrive;
    logic [W-1:0] incoming;

    always_ff @(posedge usr_clk or negedge usr_rst_n) begin
        if (!usr_rst_n) begin
            samp_q <= '0;
            prev_q <= '0;
        end else begin
            samp_q <= usr_evt;
            prev_q <= samp_q;
        end
    end

    assign rise = samp_q & ~prev_q;

    always_ff @(posedge usr_clk or negedge usr_rst_n) begin
        if (!usr_rst_n) begin
            xf_state <= XF_IDLE;
            acc_q    <= '0;
            xfer     <= '0;
            tog_u    <= 1'b0;
        end else begin
            xf_state <= state_d;
            acc_q    <= acc_d;
            xfer     <= xfer_d;
            tog_u    <= tog_d;
        end
    end

    always_comb begin
        state_d = xf_state;
        acc_d   = acc_q | rise;
        xfer_d  = xfer;
        tog_d   = tog_u;
        unique case (xf_state)
            XF_IDLE: begin
                if ((acc_q | rise) != '0) begin
                    xfer_d  = acc_q | rise;
                    acc_d   = '0;
                    tog_d   = ~tog_u;
                    state_d = XF_WAIT;
                end
            end
            XF_WAIT: begin
                if (ack_u == tog_u) begin
                    state_d = XF_IDLE;
                end
            end
            default: state_d = XF_IDLE;
        endcase
    end

    evt_sync #(.W(1), .STAGES(SYNC_STAGES)) i_tog_sync (
        .clk   (host_clk),
        .rst_n (host_rst_n),
        .d     (tog_u),
        .q     (tog_h)
    );

    assign arrive   = tog_h ^ seen_h;
    assign incoming = arrive ? xfer : '0;

    always_ff @(posedge host_clk or negedge host_rst_n) begin
        if (!host_rst_n) begin
            seen_h     <= 1'b0;
            flags      <= '0;
            poll_flags <= '0;
        end else begin
            seen_h <= tog_h;
            if (poll_req) begin
                poll_flags <= flags;
                flags      <= incoming;
            end else begin
                flags <= flags | incoming;
            end
        end
    end

    evt_sync #(.W(1), .STAGES(SYNC_STAGES)) i_ack_sync (
        .clk   (usr_clk),
        .rst_n (usr_rst_n),
        .d     (seen_h),
        .q     (ack_u)
    );

endmodule

// File: rtl/evt_trigger_bridge.sv
module evt_trigger_bridge
    import evt_bridge_pkg::*;
#(
    parameter int unsigned W           = BANK_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         host_clk,
    input  logic         host_rst_n,
    input  logic         trig_wr_en,
    input  logic [W-1:0] trig_wr_bits,
    input  logic         poll_req,
    output logic [W-1:0] poll_flags,
    input  logic         usr_clk,
    input  logic         usr_rst_n,
    input  logic [W-1:0] usr_evt,
    output logic [W-1:0] usr_trig
);

    logic [W-1:0] tin_busy;
    logic [W-1:0] tin_req_tog;
    logic [W-1:0] tout_flags;
    xfer_state_e  tout_state;
    logic [W-1:0] tout_xfer;

    evt_tin_bank #(.W(W), .SYNC_STAGES(SYNC_STAGES)) i_tin (
        .host_clk   (host_clk),
        .host_rst_n (host_rst_n),
        .wr_en      (trig_wr_en),
        .wr_bits    (trig_wr_bits),
        .usr_clk    (usr_clk),
        .usr_rst_n  (usr_rst_n),
        .usr_trig   (usr_trig),
        .busy       (tin_busy),
        .req_tog    (tin_req_tog)
    );

    evt_tout_cap #(.W(W), .SYNC_STAGES(SYNC_STAGES)) i_tout (
        .usr_clk    (usr_clk),
        .usr_rst_n  (usr_rst_n),
        .usr_evt    (usr_evt),
        .host_clk   (host_clk),
        .host_rst_n (host_rst_n),
        .poll_req   (poll_req),
        .poll_flags (poll_flags),
        .flags      (tout_flags),
        .xf_state   (tout_state),
        .xfer       (tout_xfer)
    );

endmodule

// File: rtl/evt_trigger_bridge_chk.sv
module evt_trigger_bridge_chk
    import evt_bridge_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input logic         host_clk,
    input logic         host_rst_n,
    input logic         usr_clk,
    input logic         usr_rst_n,
    input logic         poll_req,
    input logic [W-1:0] poll_flags,
    input logic [W-1:0] usr_trig,
    input logic [W-1:0] tin_busy,
    input logic [W-1:0] tin_req_tog,
    input logic [W-1:0] tout_flags,
    input xfer_state_e  tout_state,
    input logic [W-1:0] tout_xfer
);

    // R3
    pulse_width_chk: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
        (usr_trig & $past(usr_trig)) == '0);

    // R4
    lane_tog_hold_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        ((tin_req_tog ^ $past(tin_req_tog)) & $past(tin_busy)) == '0);

    // R7
    flag_sticky_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        !$past(poll_req) |-> ((tout_flags & $past(tout_flags)) == $past(tout_flags)));

    // R8
    rdata_hold_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        !$past(poll_req) |-> $stable(poll_flags));

    // R10
    xfer_stable_chk: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
        ($past(tout_state) == XF_WAIT && tout_state == XF_WAIT) |-> $stable(tout_xfer));

endmodule

bind evt_trigger_bridge evt_trigger_bridge_chk #(.W(W)) i_chk (
    .host_clk    (host_clk),
    .host_rst_n  (host_rst_n),
    .usr_clk     (usr_clk),
    .usr_rst_n   (usr_rst_n),
    .poll_req    (poll_req),
    .poll_flags  (poll_flags),
    .usr_trig    (usr_trig),
    .tin_busy    (tin_busy),
    .tin_req_tog (tin_req_tog),
    .tout_flags  (tout_flags),
    .tout_state  (tout_state),
    .tout_xfer   (tout_xfer)
);

// File: tb/test_evt_trigger_bridge.sv
module test_evt_trigger_bridge;

    localparam int W = 32;

    typedef struct packed {
        logic [W-1:0] tin;
        logic [W-1:0] tout;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{32'h0000_0001, 32'h8000_0000},
        '{32'h8000_0000, 32'h0000_0001},
        '{32'hA5A5_0F0F, 32'h0F0F_A5A5},
        '{32'hFFFF_FFFF, 32'h0000_0000},
        '{32'h0000_0000, 32'hFFFF_FFFF},
        '{32'h1248_8421, 32'h0101_0101}
    };

    logic         host_clk = 1'b0;
    logic         usr_clk  = 1'b0;
    logic         host_rst_n = 1'b0;
    logic         usr_rst_n  = 1'b0;
    logic         trig_wr_en = 1'b0;
    logic [W-1:0] trig_wr_bits = '0;
    logic         poll_req = 1'b0;
    logic [W-1:0] poll_flags;
    logic [W-1:0] usr_evt = '0;
    logic [W-1:0] usr_trig;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 host_clk = ~host_clk;
    always #7 usr_clk  = ~usr_clk;

    evt_trigger_bridge i_evt_trigger_bridge (
        .host_clk     (host_clk),
        .host_rst_n   (host_rst_n),
        .trig_wr_en   (trig_wr_en),
        .trig_wr_bits (trig_wr_bits),
        .poll_req     (poll_req),
        .poll_flags   (poll_flags),
        .usr_clk      (usr_clk),
        .usr_rst_n    (usr_rst_n),
        .usr_evt      (usr_evt),
        .usr_trig     (usr_trig)
    );

    // pulse monitor, sampled away from the user clock edge
    int           pcnt [W];
    int           base [W];
    int           wide_cnt = 0;
    logic [W-1:0] last_trig = '0;

    initial begin
        for (int b = 0; b < W; b++) pcnt[b] = 0;
    end

    always @(negedge usr_clk) begin
        for (int b = 0; b < W; b++) begin
            if (usr_trig[b]) pcnt[b] = pcnt[b] + 1;
        end
        if ((usr_trig & last_trig) != '0) wide_cnt = wide_cnt + 1;
        last_trig = usr_trig;
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic snap();
        for (int b = 0; b < W; b++) base[b] = pcnt[b];
    endtask

    task automatic pulse_vecs(output logic [W-1:0] once, output logic [W-1:0] more);
        once = '0;
        more = '0;
        for (int b = 0; b < W; b++) begin
            once[b] = (pcnt[b] - base[b]) == 1;
            more[b] = (pcnt[b] - base[b]) > 1;
        end
    endtask

    task automatic host_write(input logic [W-1:0] bits);
        @(negedge host_clk);
        trig_wr_en   = 1'b1;
        trig_wr_bits = bits;
        @(negedge host_clk);
        trig_wr_en   = 1'b0;
        trig_wr_bits = '0;
    endtask

    task automatic do_poll(output logic [W-1:0] v);
        @(negedge host_clk);
        poll_req = 1'b1;
        @(negedge host_clk);
        poll_req = 1'b0;
        v = poll_flags;
    endtask

    task automatic usr_pulse(input logic [W-1:0] bits, input int hold);
        @(negedge usr_clk);
        usr_evt = usr_evt | bits;
        repeat (hold) @(negedge usr_clk);
        usr_evt = usr_evt & ~bits;
    endtask

    task automatic settle();
        repeat (40) @(negedge host_clk);
    endtask

    initial begin
        logic [W-1:0] v, v2, once, more;
        repeat (4) @(negedge host_clk);
        host_rst_n = 1'b1;
        usr_rst_n  = 1'b1;
        repeat (3) @(negedge usr_clk);

        // R1 reset state
        check("R1 usr_trig after reset", usr_trig, '0);
        check("R1 poll_flags after reset", poll_flags, '0);
        do_poll(v);
        check("R1 first poll", v, '0);

        // table of vectors: R2 pulses, R5 edges, R8 poll
        for (int k = 0; k < NVEC; k++) begin
            snap();
            fork
                host_write(VEC[k].tin);
                usr_pulse(VEC[k].tout, 2);
            join
            settle();
            do_poll(v);
            check("R5 R8 poll after edges", v, VEC[k].tout);
            pulse_vecs(once, more);
            check("R2 pulsed bits", once, VEC[k].tin);
            check("R2 no extra pulses", more, '0);
        end
        check("R3 pulse width", W'(wide_cnt), '0);

        // R7 sticky over a long wait, R8 clear and hold
        usr_pulse(32'h0000_0020, 2);
        repeat (200) @(negedge host_clk);
        do_poll(v);
        check("R7 flag survives wait", v, 32'h0000_0020);
        repeat (20) @(negedge host_clk);
        check("R8 poll_flags held", poll_flags, 32'h0000_0020);
        do_poll(v);
        check("R8 cleared by poll", v, '0);

        // R9 several edges between polls
        for (int n = 0; n < 3; n++) begin
            usr_pulse(32'h0000_0008, 2);
            repeat (2) @(negedge usr_clk);
        end
        settle();
        do_poll(v);
        check("R9 merged edges", v, 32'h0000_0008);
        do_poll(v);
        check("R9 reported once", v, '0);

        // R6 glitch between user edges
        @(posedge usr_clk);
        #2 usr_evt[7] = 1'b1;
        #3 usr_evt[7] = 1'b0;
        settle();
        do_poll(v);
        check("R6 glitch ignored", v, '0);

        // R5 level held high gives one event
        @(negedge usr_clk);
        usr_evt[9] = 1'b1;
        settle();
        do_poll(v);
        check("R5 level first poll", v, 32'h0000_0200);
        settle();
        do_poll(v);
        check("R5 level no repeat", v, '0);
        @(negedge usr_clk);
        usr_evt[9] = 1'b0;
        settle();
        do_poll(v);
        check("R5 falling edge no event", v, '0);

        // R4 three back-to-back writes to bit 2
        snap();
        @(negedge host_clk);
        trig_wr_en   = 1'b1;
        trig_wr_bits = 32'h0000_0004;
        repeat (3) @(negedge host_clk);
        trig_wr_en   = 1'b0;
        trig_wr_bits = '0;
        settle();
        check("R4 merged request count", W'(pcnt[2] - base[2]), 32'd2);
        check("R3 pulse width after burst", W'(wide_cnt), '0);

        // R10 poll swept across event arrival
        for (int off = 0; off < 12; off++) begin
            fork
                usr_pulse(32'h0000_1000, 2);
                begin
                    repeat (off) @(negedge host_clk);
                    do_poll(v);
                end
            join
            settle();
            do_poll(v2);
            check("R10 exactly once around poll",
                  W'(int'(v[12]) + int'(v2[12])), 32'd1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge host_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule